// File: doc/BRIEF.md
# Single-Register Load/Store Address Generator

This block computes where a single-register load or store goes in memory and what the base register holds afterwards. It takes the 32-bit instruction word, the current value of the base register, the value of the offset register and the carry flag. From these it forms the offset, applies it to the base with the direction the instruction selects, and chooses between pre-indexed and post-indexed addressing. It also reports the register indices and a code for the access width and sign.

Two instruction forms are handled. The word/byte form takes either a 12-bit unsigned immediate or a register offset passed through a barrel shifter. The halfword/signed form takes either an 8-bit immediate held in two separate nibbles of the word or an unshifted register. The result is registered: an accepted instruction produces its outputs one clock later, qualified by `out_valid`. The memory interface and the alignment of loaded data are handled elsewhere.

Top module: `ls_addr_gen`

## Requirements
- R1: `base_idx` carries instruction bits 19:16 and `data_idx` carries bits 15:12 of the accepted instruction.
- R2: Bit 26 set selects the word/byte form. In this form, bit 25 clear makes the offset bits 11:0, zero-extended.
- R3: Bit 26 clear selects the halfword/signed form. In this form, bit 22 set makes the offset {bits 11:8, bits 3:0}, zero-extended. Bit 22 clear makes the offset the offset register value, unshifted.
- R4: In the word/byte form with bit 25 set, the offset is the offset register value shifted by the amount in bits 11:7. Bits 6:5 give the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R5: A zero shift amount leaves the value unchanged for a logical left shift. It yields zero for a logical right shift. For an arithmetic right shift it yields every bit equal to bit 31 of the value.
- R6: A zero shift amount with rotate right yields {carry_in, value[31:1]}, which is a one-bit rotate through carry.
- R7: Bit 23 set adds the offset to the base. Bit 23 clear subtracts it, modulo 2^32.
- R8: Bit 24 set is pre-indexed. The address is the base combined with the offset. `wb_en` equals bit 21. `wb_data` equals the address.
- R9: Bit 24 clear is post-indexed. The address is the unmodified base. `wb_en` is 1. `wb_data` is the base combined with the offset.
- R10: `acc_width` is 0 for a word and 1 for a byte in the word/byte form, where bit 22 selects byte. In the halfword/signed form, bits 6:5 decide the code: 10 gives 3 (signed byte), 11 gives 4 (signed halfword), and 01 or 00 gives 2 (halfword).
- R11: Outputs appear one cycle after `in_valid`, with `out_valid` high for exactly that cycle. Reset holds `out_valid` low and clears all outputs, whatever `in_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| instr | input | 32 | Load/store instruction word |
| base_val | input | DATA_W | Current base register value |
| offs_val | input | DATA_W | Offset register value |
| carry_in | input | 1 | Carry flag, used by rotate-through-carry |
| out_valid | output | 1 | Registered results are valid |
| acc_addr | output | DATA_W | Effective access address |
| acc_width | output | 3 | Access width/sign code |
| wb_en | output | 1 | Base register must be updated |
| wb_data | output | DATA_W | New base value |
| base_idx | output | 4 | Base register index |
| data_idx | output | 4 | Data register index |

## Verification
Directed words cover each offset source (the 12-bit immediate, the split-nibble immediate, the plain register and the shifted register) on the same base. A wrong source selection therefore shows up as a distinct address. The shifter is tested with non-zero amounts and with zero amounts for all four kinds. A negative offset separates the zero-amount arithmetic case from the logical one, and both carry values are used to expose the rotate-through-carry case. Every combination of the pre, up and writeback bits is applied, so that address, writeback enable and writeback value are told apart between indexing modes. A long run of arbitrary instruction words back to back then covers the width codes and mixed forms.

// File: rtl/ls_agen_pkg.sv
package ls_agen_pkg;

    localparam int INSTR_W = 32;
    localparam int IDX_W   = 4;
    localparam int AMT_W   = 5;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [2:0] {
        ACW_WORD  = 3'd0,
        ACW_BYTE  = 3'd1,
        ACW_HALF  = 3'd2,
        ACW_SBYTE = 3'd3,
        ACW_SHALF = 3'd4
    } acc_width_e;

    typedef struct packed {
        logic              wb_form;   // word/byte form
        logic              reg_off;   // word/byte: register offset
        logic              bit22;     // byte select or split-immediate select
        logic              pre;
        logic              up;
        logic              wback;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rd;
        logic [11:0]       low12;
    } ls_fields_t;

    function automatic ls_fields_t split_fields(input logic [INSTR_W-1:0] w);
        ls_fields_t f;
        f.wb_form = w[26];
        f.reg_off = w[25];
        f.bit22   = w[22];
        f.pre     = w[24];
        f.up      = w[23];
        f.wback   = w[21];
        f.rn      = w[19:16];
        f.rd      = w[15:12];
        f.low12   = w[11:0];
        return f;
    endfunction

    function automatic acc_width_e width_code(input ls_fields_t f);
        if (f.wb_form)
            return f.bit22 ? ACW_BYTE : ACW_WORD;
        case (f.low12[6:5])
            2'b10:   return ACW_SBYTE;
            2'b11:   return ACW_SHALF;
            default: return ACW_HALF;
        endcase
    endfunction

endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
    import ls_agen_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amount,
    input  logic              carry,
    output logic [DATA_W-1:0] result
);
    logic [2*DATA_W-1:0] doubled;

    always_comb begin
        doubled = {value, value} >> amount;
        result  = value;
        case (kind)
            SHK_LSL: result = value << amount;
            SHK_LSR: result = (amount == '0) ? '0 : (value >> amount);
            SHK_ASR: result = (amount == '0) ? {DATA_W{value[DATA_W-1]}}
                                             : DATA_W'($signed(value) >>> amount);
            SHK_ROR: result = (amount == '0) ? {carry, value[DATA_W-1:1]}
                                             : doubled[DATA_W-1:0];
            default: result = value;
        endcase
    end
endmodule

// File: rtl/lsag_offset.sv
module lsag_offset
    import ls_agen_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  ls_fields_t        f,
    input  logic [DATA_W-1:0] offs_val,
    input  logic              carry,
    output logic [DATA_W-1:0] offset
);
    logic [DATA_W-1:0] shifted;

    lsag_shifter #(.DATA_W(DATA_W)) u_shift (
        .value  (offs_val),
        .kind   (shift_kind_e'(f.low12[6:5])),
        .amount (f.low12[11:7]),
        .carry  (carry),
        .result (shifted)
    );

    always_comb begin
        if (f.wb_form)
            offset = f.reg_off ? shifted : DATA_W'(f.low12);
        else
            offset = f.bit22 ? DATA_W'({f.low12[11:8], f.low12[3:0]}) : offs_val;
    end
endmodule

// File: rtl/lsag_index.sv
module lsag_index
    import ls_agen_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  ls_fields_t        f,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] offset,
    output logic [DATA_W-1:0] addr,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data
);
    logic [DATA_W-1:0] moved;

    always_comb begin
        moved   = f.up ? (base_val + offset) : (base_val - offset);
        addr    = f.pre ? moved : base_val;
        wb_en   = ~f.pre | f.wback;
        wb_data = moved;
    end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import ls_agen_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] offs_val,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] acc_addr,
    output logic [2:0]        acc_width,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data,
    output logic [3:0]        base_idx,
    output logic [3:0]        data_idx
);
    ls_fields_t        fld;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] nx_addr;
    logic [DATA_W-1:0] nx_wbd;
    logic              nx_wben;

    assign fld = split_fields(instr);

    lsag_offset #(.DATA_W(DATA_W)) u_offset (
        .f        (fld),
        .offs_val (offs_val),
        .carry    (carry_in),
        .offset   (offset)
    );

    lsag_index #(.DATA_W(DATA_W)) u_index (
        .f        (fld),
        .base_val (base_val),
        .offset   (offset),
        .addr     (nx_addr),
        .wb_en    (nx_wben),
        .wb_data  (nx_wbd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            acc_addr  <= '0;
            acc_width <= '0;
            wb_en     <= 1'b0;
            wb_data   <= '0;
            base_idx  <= '0;
            data_idx  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_addr  <= nx_addr;
                acc_width <= width_code(fld);
                wb_en     <= nx_wben;
                wb_data   <= nx_wbd;
                base_idx  <= fld.rn;
                data_idx  <= fld.rd;
            end
        end
    end

    // R9: post-indexed access addresses the untouched base and always writes back
    p_post_base_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !instr[24]) |=> (acc_addr == $past(base_val) && wb_en));

    // R8: pre-indexed access writes back the address itself, enable from bit 21
    p_pre_wb_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[24]) |=> (wb_data == acc_addr && wb_en == $past(instr[21])));

    // R7: down direction with the 12-bit immediate subtracts it from the base
    p_down_imm_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[26] && !instr[25] && !instr[23])
        |=> (wb_data == $past(base_val) - DATA_W'($past(instr[11:0]))));

    // R5: zero-amount left shift passes the register through unchanged
    p_lsl_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[26] && instr[25] && instr[23] && instr[11:5] == 7'd0)
        |=> (wb_data == $past(base_val) + $past(offs_val)));

    // R3: split immediate is rebuilt from the two nibbles
    p_split_imm_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !instr[26] && instr[22] && instr[23])
        |=> (wb_data == $past(base_val) + DATA_W'({$past(instr[11:8]), $past(instr[3:0])})));

    // R11: reset keeps the output qualifier low
    p_reset_idle_r11: assert property (@(posedge clk) rst |=> !out_valid);

    // R1: register indices follow the accepted word
    p_indices_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (base_idx == $past(instr[19:16]) && data_idx == $past(instr[15:12])));

endmodule

// File: tb/test_ls_addr_gen.sv
module test_ls_addr_gen;

    localparam int  DW = 32;
    localparam time TCK = 20ns;
    localparam int  WD_CYCLES = 150000;

    typedef struct {
        logic [DW-1:0] addr;
        logic [2:0]    width;
        logic          wbe;
        logic [DW-1:0] wbd;
        logic [3:0]    bi;
        logic [3:0]    di;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [DW-1:0] base_val = '0;
    logic [DW-1:0] offs_val = '0;
    logic          carry_in = 1'b0;
    logic          out_valid;
    logic [DW-1:0] acc_addr;
    logic [2:0]    acc_width;
    logic          wb_en;
    logic [DW-1:0] wb_data;
    logic [3:0]    base_idx;
    logic [3:0]    data_idx;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    always #(TCK/2) clk = ~clk;

    ls_addr_gen #(.DATA_W(DW)) i_ls_addr_gen (
        .clk, .rst, .in_valid, .instr, .base_val, .offs_val, .carry_in,
        .out_valid, .acc_addr, .acc_width, .wb_en, .wb_data, .base_idx, .data_idx
    );

    function automatic exp_t model(input logic [31:0] w, input logic [DW-1:0] b,
                                   input logic [DW-1:0] o, input logic c, input string tag);
        exp_t e;
        logic [DW-1:0] off;
        logic [DW-1:0] sum;
        int a;
        a = int'(w[11:7]);
        if (w[26]) begin
            if (!w[25]) off = {20'd0, w[11:0]};
            else begin
                case (w[6:5])
                    2'b00: off = o << a;
                    2'b01: off = (a == 0) ? 32'd0 : o >> a;
                    2'b10: off = (a == 0) ? (o[31] ? 32'hFFFF_FFFF : 32'd0)
                                          : 32'($signed(o) >>> a);
                    default: off = (a == 0) ? {c, o[31:1]} : ((o >> a) | (o << (32 - a)));
                endcase
            end
            e.width = w[22] ? 3'd1 : 3'd0;
        end else begin
            off = w[22] ? {24'd0, w[11:8], w[3:0]} : o;
            e.width = (w[6:5] == 2'b10) ? 3'd3 : (w[6:5] == 2'b11) ? 3'd4 : 3'd2;
        end
        sum    = w[23] ? b + off : b - off;
        e.addr = w[24] ? sum : b;
        e.wbe  = !w[24] || w[21];
        e.wbd  = sum;
        e.bi   = w[19:16];
        e.di   = w[15:12];
        e.tag  = tag;
        return e;
    endfunction

    function automatic logic [31:0] ins_wi(bit p, bit u, bit bb, bit wb, logic [3:0] rn,
                                          logic [3:0] rd, logic [11:0] imm);
        return {4'hE, 2'b01, 1'b0, p, u, bb, wb, 1'b1, rn, rd, imm};
    endfunction

    function automatic logic [31:0] ins_wr(bit p, bit u, bit wb, logic [4:0] amt,
                                          logic [1:0] kind, logic [3:0] rm);
        return {4'hE, 2'b01, 1'b1, p, u, 1'b0, wb, 1'b1, 4'd2, 4'd7, amt, kind, 1'b0, rm};
    endfunction

    function automatic logic [31:0] ins_hw(bit p, bit u, bit imf, bit wb, logic [3:0] hi,
                                          logic [1:0] sh, logic [3:0] lo);
        return {4'hE, 3'b000, p, u, imf, wb, 1'b1, 4'd9, 4'd4, hi, 1'b1, sh, 1'b1, lo};
    endfunction

    task automatic apply(input logic [31:0] w, input logic [DW-1:0] b,
                         input logic [DW-1:0] o, input logic c, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = w;
        base_val = b;
        offs_val = o;
        carry_in = c;
        sb.push_back(model(w, b, o, c, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compare against the scoreboard one cycle after each accepted word
    always @(posedge clk) begin
        #5ns;
        if (!rst && !done) begin
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (!out_valid) begin
                    n_bad++;
                    $display("FAIL R11: out_valid=%0b expected 1 (%s)", out_valid, e.tag);
                end else if (acc_addr !== e.addr || acc_width !== e.width || wb_en !== e.wbe
                             || wb_data !== e.wbd || base_idx !== e.bi || data_idx !== e.di) begin
                    n_bad++;
                    $display("FAIL %s: addr=%h width=%0d wben=%0b wbd=%h bi=%0d di=%0d expected addr=%h width=%0d wben=%0b wbd=%h bi=%0d di=%0d",
                             e.tag, acc_addr, acc_width, wb_en, wb_data, base_idx, data_idx,
                             e.addr, e.width, e.wbe, e.wbd, e.bi, e.di);
                end
            end else if (out_valid !== 1'b0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R11: out_valid=%0b expected 0 with nothing pending", out_valid);
            end
        end
    end

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        // R11: valid input during reset must produce nothing
        in_valid = 1'b1;
        instr    = ins_wi(1, 1, 0, 1, 4'd3, 4'd5, 12'h123);
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || acc_addr !== '0 || wb_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: reset state valid=%0b addr=%h wben=%0b expected 0/0/0",
                     out_valid, acc_addr, wb_en);
        end
        in_valid = 1'b0;
        rst = 1'b0;
        idle(2);

        // R2 R7 R8: 12-bit immediate, pre-indexed, both directions, writeback on/off
        apply(ins_wi(1, 1, 0, 0, 4'd3, 4'd5, 12'h123), 32'h0000_1000, 32'h0, 1'b0, "R2_R8");
        apply(ins_wi(1, 0, 0, 0, 4'd3, 4'd5, 12'hFFF), 32'h0001_0000, 32'h0, 1'b0, "R7");
        apply(ins_wi(1, 1, 1, 1, 4'd13, 4'd1, 12'h004), 32'h2000_0000, 32'h0, 1'b0, "R8_R10");
        apply(ins_wi(1, 0, 0, 1, 4'd0, 4'd15, 12'h010), 32'h0000_0008, 32'h0, 1'b0, "R7_R8");
        // R9: post-indexed always writes back
        apply(ins_wi(0, 1, 0, 0, 4'd6, 4'd8, 12'h020), 32'h0000_4000, 32'h0, 1'b0, "R9");
        apply(ins_wi(0, 0, 1, 1, 4'd6, 4'd8, 12'h020), 32'h0000_4000, 32'h0, 1'b0, "R9_R1");
        idle(1);
        // R4: non-zero shifts of the offset register
        apply(ins_wr(1, 1, 0, 5'd4, 2'b00, 4'd1), 32'h100, 32'h0000_0011, 1'b0, "R4_lsl");
        apply(ins_wr(1, 1, 0, 5'd8, 2'b01, 4'd1), 32'h100, 32'h8000_1200, 1'b0, "R4_lsr");
        apply(ins_wr(1, 1, 0, 5'd3, 2'b10, 4'd1), 32'h100, 32'hFFFF_FF00, 1'b0, "R4_asr");
        apply(ins_wr(1, 1, 0, 5'd8, 2'b11, 4'd1), 32'h100, 32'h0000_00AB, 1'b0, "R4_ror");
        // R5: zero amounts
        apply(ins_wr(1, 1, 0, 5'd0, 2'b00, 4'd1), 32'h100, 32'h8765_4321, 1'b0, "R5_lsl0");
        apply(ins_wr(1, 1, 0, 5'd0, 2'b01, 4'd1), 32'h100, 32'hFFFF_FFFF, 1'b0, "R5_lsr0");
        apply(ins_wr(1, 1, 0, 5'd0, 2'b10, 4'd1), 32'h100, 32'h8000_0000, 1'b0, "R5_asr0_neg");
        apply(ins_wr(1, 0, 0, 5'd0, 2'b10, 4'd1), 32'h100, 32'h7FFF_FFFF, 1'b0, "R5_asr0_pos");
        // R6: rotate through carry, both carry values
        apply(ins_wr(1, 1, 0, 5'd0, 2'b11, 4'd1), 32'h0, 32'h0000_0003, 1'b1, "R6_c1");
        apply(ins_wr(0, 1, 0, 5'd0, 2'b11, 4'd1), 32'h0, 32'h8000_0003, 1'b0, "R6_c0");
        idle(2);
        // R3 R10: halfword/signed form
        apply(ins_hw(1, 1, 1, 0, 4'hA, 2'b01, 4'h5), 32'h3000, 32'hDEAD, 1'b0, "R3_imm_R10_h");
        apply(ins_hw(1, 0, 1, 1, 4'hF, 2'b10, 4'hF), 32'h3000, 32'hDEAD, 1'b0, "R3_imm_R10_sb");
        apply(ins_hw(0, 1, 0, 0, 4'h7, 2'b11, 4'h2), 32'h3000, 32'h0000_0044, 1'b0, "R3_reg_R10_sh");
        apply(ins_hw(1, 1, 0, 0, 4'h0, 2'b00, 4'h2), 32'h3000, 32'h0000_0044, 1'b0, "R3_R10_sh00");
        idle(1);

        // mixed arbitrary words, back to back
        for (int k = 0; k < 200; k++) begin
            apply($urandom, $urandom, $urandom, 1'($urandom), "R1_R10_mixed");
            if (k % 37 == 36) idle(1);
        end
        idle(3);

        done = 1'b1;
        n_vec++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R11: %0d results never appeared, expected 0", sb.size());
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule